// File: doc/BRIEF.md
# Fast-Acquire Charge Pump Current Controller

This block sits beside the phase-frequency detector of an integer-N synthesizer and picks the charge pump current for the next correction pulse. It runs on the reference clock. While either detector output is high, it counts reference cycles in units of a measurement period T. T is the reference period multiplied by a programmable divisor. When the pulse ends, the count becomes a current multiple, and that multiple is applied to the following pulse.

A nominal current is programmed as a 3-bit code. When fast acquire is off, the block always drives the nominal current. When fast acquire is on, a wide phase error raises the current so the loop settles faster. The current never falls below nominal, and it has a floor of two units when the nominal code is at its minimum. The output is a registered binary multiple of the minimum current unit, from 1 to 8.

Top module: `cp_fast_acq`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `cp_mult` equals `nom_code + 1`. Reset also discards any measured width, so a multiple of 1 is used until a new pulse ends.
- R2: With `fast_en` low, `cp_mult` equals `nom_code + 1` whatever the detector pulses do.
- R3: A pulse is a run of W consecutive cycles with `pfd_up` or `pfd_dn` high. Its multiple is k = floor(W / T) + 1, where T is `divisor`.
- R4: k saturates at 8 for every W of at least 7T.
- R5: A `divisor` of 0 measures exactly like a `divisor` of 1.
- R6: With `fast_en` high, `cp_mult` equals the larger of k from the last completed pulse and `nom_code + 1`.
- R7: With `fast_en` high and `nom_code` equal to 0, `cp_mult` is never below 2, even when k is 1.
- R8: k is taken when a pulse ends. During a pulse, `cp_mult` still reflects the previous pulse. The new value appears by the second rising edge after the first cycle with both detector inputs low.
- R9: Clearing `fast_en` discards the stored multiple. After re-enabling, and before another pulse ends, `cp_mult` is `max(nom_code + 1, 1)`, with the R7 floor applied.
- R10: `nom_code` n (0 to 7) selects n + 1 units. `cp_mult` is an unsigned 4-bit count of units and always lies between 1 and 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; the unit of width measurement |
| rst | input | 1 | Synchronous active-high reset |
| pfd_up | input | 1 | Detector UP pulse, synchronous to clk |
| pfd_dn | input | 1 | Detector DOWN pulse, synchronous to clk |
| fast_en | input | 1 | Fast acquire enable |
| nom_code | input | 3 | Nominal current code, n selects n+1 units |
| divisor | input | DIV_W (8) | Measurement period in reference cycles; 0 acts as 1 |
| cp_mult | output | 4 | Registered current multiple, 1 to 8 |

## Verification
The bench probes pulse widths that sit exactly on multiples of T. An off-by-one comparison in the period counter would report k one step high or low at W = T and W = 7T. It also probes widths far beyond 7T: if the quotient wrapped instead of saturating, the current would drop back to a small value. Further tests cover a zero divisor, a nominal code of 0 with short pulses, and checks taken in the middle of a pulse. A design without the floor would output 1 unit for short pulses, and a design that updated early would change the current before the pulse ended. Toggling the enable and reset after a wide pulse exposes a design that keeps a stale wide multiple when the loop is re-enabled.

// File: rtl/cp_fa_pkg.sv
package cp_fa_pkg;
  localparam int NOM_W      = 3;
  localparam int MAX_MULT   = 8;
  localparam int MULT_W     = $clog2(MAX_MULT + 1);
  localparam int FAST_FLOOR = 2;
endpackage

// File: rtl/cp_width_meter.sv
// Counts reference cycles of a detector pulse in units of T and
// stores k = floor(W/T)+1 (saturated) when the pulse ends.
module cp_width_meter #(
  parameter int DIV_W    = 8,
  parameter int MAX_MULT = cp_fa_pkg::MAX_MULT,
  parameter int MULT_W   = cp_fa_pkg::MULT_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              active,
  input  logic [DIV_W-1:0]  divisor,
  output logic [MULT_W-1:0] k_q
);
  localparam int Q_W = $clog2(MAX_MULT);
  localparam logic [Q_W-1:0] Q_MAX = Q_W'(MAX_MULT - 1);

  logic [DIV_W-1:0] t_last;
  logic [DIV_W-1:0] sub_cnt;
  logic [Q_W-1:0]   quo;
  logic             act_d;

  // zero divisor behaves as one: terminal count of zero either way
  assign t_last = (divisor == '0) ? '0 : divisor - DIV_W'(1);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      act_d   <= 1'b0;
      sub_cnt <= '0;
      quo     <= '0;
      k_q     <= MULT_W'(1);
    end else begin
      act_d <= active;
      if (active) begin
        if (sub_cnt == t_last) begin
          sub_cnt <= '0;
          if (quo != Q_MAX) quo <= quo + Q_W'(1);
        end else begin
          sub_cnt <= sub_cnt + DIV_W'(1);
        end
      end else begin
        sub_cnt <= '0;
        quo     <= '0;
        if (act_d) k_q <= MULT_W'(quo) + MULT_W'(1);
      end
    end
  end
endmodule

// File: rtl/cp_current_select.sv
// Picks the multiple for the next pulse from the measured k and the
// nominal code.
module cp_current_select #(
  parameter int NOM_W      = cp_fa_pkg::NOM_W,
  parameter int MULT_W     = cp_fa_pkg::MULT_W,
  parameter int FAST_FLOOR = cp_fa_pkg::FAST_FLOOR
) (
  input  logic [MULT_W-1:0] k_meas,
  input  logic [NOM_W-1:0]  nom_code,
  input  logic              fast_en,
  output logic [MULT_W-1:0] nom_mult,
  output logic [MULT_W-1:0] sel_mult
);
  logic [MULT_W-1:0] fa_mult;

  assign nom_mult = MULT_W'(nom_code) + MULT_W'(1);

  always_comb begin
    fa_mult = (k_meas > nom_mult) ? k_meas : nom_mult;
    if (nom_code == '0 && fa_mult < MULT_W'(FAST_FLOOR))
      fa_mult = MULT_W'(FAST_FLOOR);
    sel_mult = fast_en ? fa_mult : nom_mult;
  end
endmodule

// File: rtl/cp_fast_acq.sv
module cp_fast_acq
  import cp_fa_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pfd_up,
  input  logic              pfd_dn,
  input  logic              fast_en,
  input  logic [NOM_W-1:0]  nom_code,
  input  logic [DIV_W-1:0]  divisor,
  output logic [MULT_W-1:0] cp_mult
);
  logic [MULT_W-1:0] k_meas;
  logic [MULT_W-1:0] nom_mult;
  logic [MULT_W-1:0] sel_mult;

  cp_width_meter #(
    .DIV_W(DIV_W), .MAX_MULT(MAX_MULT), .MULT_W(MULT_W)
  ) u_meter (
    .clk(clk), .rst(rst), .clr(!fast_en),
    .active(pfd_up | pfd_dn), .divisor(divisor), .k_q(k_meas)
  );

  cp_current_select #(
    .NOM_W(NOM_W), .MULT_W(MULT_W), .FAST_FLOOR(FAST_FLOOR)
  ) u_select (
    .k_meas(k_meas), .nom_code(nom_code), .fast_en(fast_en),
    .nom_mult(nom_mult), .sel_mult(sel_mult)
  );

  always_ff @(posedge clk) begin
    if (rst) cp_mult <= nom_mult;
    else     cp_mult <= sel_mult;
  end
endmodule

// File: rtl/cp_fast_acq_sva.sv
module cp_fast_acq_sva #(
  parameter int NOM_W    = 3,
  parameter int MULT_W   = 4,
  parameter int MAX_MULT = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              fast_en,
  input logic [NOM_W-1:0]  nom_code,
  input logic [MULT_W-1:0] cp_mult
);
  a_r1_reset_nominal: assert property (@(posedge clk)
    rst |=> cp_mult == MULT_W'($past(nom_code)) + MULT_W'(1));

  a_r2_disabled_nominal: assert property (@(posedge clk) disable iff (rst)
    !fast_en |=> cp_mult == MULT_W'($past(nom_code)) + MULT_W'(1));

  a_r6_not_below_nominal: assert property (@(posedge clk) disable iff (rst)
    fast_en |=> cp_mult >= MULT_W'($past(nom_code)) + MULT_W'(1));

  a_r7_min_floor: assert property (@(posedge clk) disable iff (rst)
    (fast_en && nom_code == '0) |=> cp_mult >= MULT_W'(2));

  a_r10_range: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cp_mult >= MULT_W'(1) && cp_mult <= MULT_W'(MAX_MULT)));
endmodule

bind cp_fast_acq cp_fast_acq_sva #(
  .NOM_W(cp_fa_pkg::NOM_W), .MULT_W(cp_fa_pkg::MULT_W), .MAX_MULT(cp_fa_pkg::MAX_MULT)
) u_chk (
  .clk(clk), .rst(rst), .fast_en(fast_en), .nom_code(nom_code), .cp_mult(cp_mult)
);

// File: tb/cp_fast_acq_tb.sv
module cp_fast_acq_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pfd_up = 1'b0;
  logic       pfd_dn = 1'b0;
  logic       fast_en = 1'b0;
  logic [2:0] nom_code = 3'd3;
  logic [7:0] divisor = 8'd1;
  logic [3:0] cp_mult;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cp_fast_acq #(.DIV_W(8)) u_dut (
    .clk(clk), .rst(rst), .pfd_up(pfd_up), .pfd_dn(pfd_dn),
    .fast_en(fast_en), .nom_code(nom_code), .divisor(divisor), .cp_mult(cp_mult)
  );

  // {nom 3, fast_en 1, divisor 8, width 8, expected 4}
  localparam int NV = 16;
  localparam logic [23:0] VEC [NV] = '{
    {3'd0, 1'b1, 8'd4,   8'd2,   4'd2},  // R7 floor, k=1
    {3'd0, 1'b1, 8'd4,   8'd4,   4'd2},  // R3 W=T
    {3'd0, 1'b1, 8'd4,   8'd9,   4'd3},  // R3
    {3'd0, 1'b1, 8'd4,   8'd100, 4'd8},  // R4 saturation
    {3'd0, 1'b1, 8'd2,   8'd13,  4'd7},  // R3 just below 7T
    {3'd0, 1'b1, 8'd2,   8'd14,  4'd8},  // R4 exactly 7T
    {3'd2, 1'b1, 8'd4,   8'd5,   4'd3},  // R6 nominal wins
    {3'd2, 1'b1, 8'd3,   8'd13,  4'd5},  // R6 width wins
    {3'd7, 1'b1, 8'd1,   8'd3,   4'd8},  // R10 top nominal
    {3'd3, 1'b1, 8'd0,   8'd5,   4'd6},  // R5 divisor 0
    {3'd3, 1'b1, 8'd0,   8'd1,   4'd4},  // R5 divisor 0, short
    {3'd5, 1'b0, 8'd1,   8'd20,  4'd6},  // R2 disabled
    {3'd0, 1'b0, 8'd1,   8'd50,  4'd1},  // R2 disabled, minimum
    {3'd1, 1'b1, 8'd2,   8'd7,   4'd4},  // R6
    {3'd4, 1'b1, 8'd255, 8'd10,  4'd5},  // R3 long period
    {3'd0, 1'b1, 8'd1,   8'd1,   4'd2}   // R3 T=1 W=1 gives 2
  };

  task automatic check(input logic [3:0] exp, input string tag);
    checks++;
    if (cp_mult !== exp) begin
      errors++;
      $display("FAIL %s: cp_mult=%0d expected=%0d", tag, cp_mult, exp);
    end
  endtask

  task automatic pulse(input int w, input bit use_dn);
    for (int i = 0; i < w; i++) begin
      pfd_up = !use_dn;
      pfd_dn = use_dn;
      @(negedge clk);
    end
    pfd_up = 1'b0;
    pfd_dn = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(4'd4, "R1 reset value nom=3");
    rst = 1'b0;
    @(negedge clk);
    check(4'd4, "R1 first cycle after reset");

    for (int v = 0; v < NV; v++) begin
      nom_code = VEC[v][23:21];
      fast_en  = VEC[v][20];
      divisor  = VEC[v][19:12];
      @(negedge clk);
      pulse(int'(VEC[v][11:4]), v[0]);
      settle();
      check(VEC[v][3:0], $sformatf("R3/R6 vector %0d", v));
    end

    // R8: value held during a pulse, updated after it ends
    nom_code = 3'd0; fast_en = 1'b1; divisor = 8'd2;
    @(negedge clk);
    pulse(20, 1'b0);
    settle();
    check(4'd8, "R8 wide pulse stored");
    pfd_up = 1'b1;
    repeat (2) @(negedge clk);
    check(4'd8, "R8 held mid-pulse");
    pfd_up = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(4'd2, "R8 updated two edges after end");

    // R6: nominal change applies without a new pulse
    pulse(5, 1'b1);
    settle();
    check(4'd3, "R6 k=3 nom=0");
    nom_code = 3'd5;
    @(negedge clk);
    check(4'd6, "R6 nominal raised above k");

    // R9: clearing enable discards the stored multiple
    nom_code = 3'd0;
    pulse(30, 1'b0);
    settle();
    check(4'd8, "R9 precondition k=8");
    fast_en = 1'b0;
    @(negedge clk);
    check(4'd1, "R9 disabled gives nominal");
    fast_en = 1'b1;
    settle();
    check(4'd2, "R9 re-enabled, stored width gone");

    // R1: reset discards the stored multiple
    pulse(30, 1'b1);
    settle();
    check(4'd8, "R1 precondition k=8");
    nom_code = 3'd2;
    rst = 1'b1;
    @(negedge clk);
    check(4'd3, "R1 reset during fast acquire");
    rst = 1'b0;
    settle();
    check(4'd3, "R1 stored width cleared by reset");

    // R2: pulses ignored while disabled
    fast_en = 1'b0;
    nom_code = 3'd6;
    pulse(40, 1'b0);
    settle();
    check(4'd7, "R2 pulse ignored when disabled");

    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule